// File: doc/BRIEF.md
# Page-Write Byte Load Controller

This block is a clocked model of the write front end of a parallel EEPROM. The chip-enable, write-enable and output-enable strobes reach it already synchronized to the clock. It decides which strobe activity counts as a real byte load and collects the loaded bytes in a page buffer. When the host goes quiet, it hands the buffered page to an internal programming timer.

A load opens when the last of chip enable and write enable goes low while output enable is high. The address is taken at that point. The load closes when the first of the two strobes returns high, and the data is taken at that point. A load must stay open for a minimum number of cycles, or it is treated as a glitch and discarded. The first accepted load locks the page address held in the upper address bits. Every load restarts a retriggerable window. When the window expires with bytes buffered, the block emits a one-cycle commit pulse that carries the page address, then stays busy for the programming time. When programming ends, the buffer empties and the page lock is released.

Writes are refused until a power-on delay has elapsed after the power-good input rises. Writes are also refused for as long as programming is busy. The load window, the programming time, the power-on delay and the minimum strobe width are parameters counted in clock cycles.

Top module: `pgwr_ctrl`

## Requirements
- R1: A byte load opens only while chip enable is low, write enable is low and output enable is high. With output enable low, or with only one of chip enable or write enable low, nothing is buffered.
- R2: The address is taken in the first cycle in which chip enable and write enable are both low; later changes to it are ignored. The data is taken in the first cycle in which either strobe is high again; data shown only earlier or later is ignored.
- R3: A load that stays open for fewer than MIN_LOW clock cycles is discarded. A load that stays open for exactly MIN_LOW cycles is accepted.
- R4: Each load restarts the load window. Programming does not start while loads keep arriving less than LOAD_WIN cycles apart. It starts about LOAD_WIN cycles after the start of the last load.
- R5: The first accepted load locks the page, which is address bits 16 down to 8. A later load to another page is dropped, and it sets page_err, which stays high until reset.
- R6: Programming starts with commit high for exactly one cycle, with commit_page equal to the locked page. busy is then high for exactly PROG_CYC cycles, starting in the commit cycle.
- R7: While busy is high, strobes are ignored and buf_valid does not change.
- R8: Until PON_CYC cycles have passed with pwr_good high, no load is accepted.
- R9: A second load to the same offset in one page operation replaces the byte buffered there. Bit k of buf_valid marks offset k, and the byte sits at buf_data[8k+7:8k].
- R10: buf_valid reads all zero in the same cycle that busy falls. After that, a load to any page is accepted and locks that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply good indication |
| ce_n | input | 1 | Chip enable, active low, synchronized |
| we_n | input | 1 | Write enable, active low, synchronized |
| oe_n | input | 1 | Output enable, active low, synchronized |
| addr | input | 17 | Byte address; bits 16:8 are the page, bits 7:0 the offset |
| din | input | 8 | Write data |
| busy | output | 1 | Programming in progress |
| commit | output | 1 | One-cycle pulse when programming starts |
| commit_page | output | 9 | Locked page address |
| buf_data | output | 2048 | Page buffer, byte k at bits 8k+7:8k |
| buf_valid | output | 256 | Per-offset valid mask |
| page_err | output | 1 | Sticky flag for a load to a foreign page |

## Verification
The strobes are driven in several patterns: a valid load with output enable low, a load with only one strobe low, staggered strobe falls with the address moved mid-load, and staggered rises with the data switched at the rise. Together these show whether the address and data are taken at the right edges, rather than only whether a load happens. Loads held open for MIN_LOW-1 and for MIN_LOW cycles show where glitch rejection begins. Chains of loads spaced just inside the window show that the window retriggers, rather than timing from the first load. A foreign-page load, a repeated offset, and strobes during busy each test whether the buffer mask is left exactly as the rules require.

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
  parameter int ADDR_W   = 17,
  parameter int OFF_W    = 8,
  parameter int DATA_W   = 8,
  parameter int LOAD_WIN = 20000,
  parameter int PROG_CYC = 1000000,
  parameter int PON_CYC  = 1000000,
  parameter int MIN_LOW  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             pwr_good,
  input  logic                             ce_n,
  input  logic                             we_n,
  input  logic                             oe_n,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                din,
  output logic                             busy,
  output logic                             commit,
  output logic [ADDR_W-OFF_W-1:0]          commit_page,
  output logic [(1<<OFF_W)*DATA_W-1:0]     buf_data,
  output logic [(1<<OFF_W)-1:0]            buf_valid,
  output logic                             page_err
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int NBYTES = 1 << OFF_W;
  localparam int WIN_W  = $clog2(LOAD_WIN + 1);
  localparam int PRG_W  = $clog2(PROG_CYC + 1);
  localparam int PON_W  = $clog2(PON_CYC + 1);
  localparam int LOW_W  = $clog2(MIN_LOW + 1);

  logic [PON_W-1:0]  pon_cnt;
  logic [LOW_W-1:0]  low_cnt;
  logic [WIN_W-1:0]  win_cnt;
  logic [PRG_W-1:0]  prg_cnt;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] mem [NBYTES];
  logic              act, act_q;

  wire pon_done = pon_cnt == PON_W'(PON_CYC);
  wire ok       = pon_done & ~busy;
  assign act    = ~ce_n & ~we_n & oe_n & ok;
  wire open_ev  = act & ~act_q;
  wire ld       = act_q & ~act & ok & (low_cnt >= LOW_W'(MIN_LOW));
  wire [PAGE_W-1:0] lat_page = lat_addr[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0]  lat_off  = lat_addr[OFF_W-1:0];
  wire locked   = |buf_valid;
  wire hit      = ~locked | (lat_page == commit_page);
  wire launch   = locked & ~act & ~act_q & ~busy & (win_cnt >= WIN_W'(LOAD_WIN));
  wire done     = busy & (prg_cnt == PRG_W'(PROG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pon_cnt <= '0;
    else if (!pwr_good)        pon_cnt <= '0;
    else if (!pon_done)        pon_cnt <= pon_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q    <= 1'b0;
      low_cnt  <= '0;
      lat_addr <= '0;
    end else begin
      act_q <= act;
      if (open_ev) begin
        lat_addr <= addr;
        low_cnt  <= LOW_W'(1);
      end else if (act && low_cnt < LOW_W'(MIN_LOW)) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          win_cnt <= '0;
    else if (open_ev)                    win_cnt <= '0;
    else if (win_cnt < WIN_W'(LOAD_WIN)) win_cnt <= win_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy    <= 1'b0;
      prg_cnt <= '0;
      commit  <= 1'b0;
    end else begin
      commit <= launch;
      if (launch) begin
        busy    <= 1'b1;
        prg_cnt <= '0;
      end else if (done) begin
        busy <= 1'b0;
      end else if (busy) begin
        prg_cnt <= prg_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      buf_valid   <= '0;
      commit_page <= '0;
      page_err    <= 1'b0;
    end else begin
      if (done)               buf_valid <= '0;
      else if (ld && hit)     buf_valid[lat_off] <= 1'b1;
      if (ld && !locked)      commit_page <= lat_page;
      if (ld && !hit)         page_err <= 1'b1;
    end

  always_ff @(posedge clk)
    if (ld && hit) mem[lat_off] <= din;

  for (genvar g = 0; g < NBYTES; g++) begin : g_flat
    assign buf_data[g*DATA_W +: DATA_W] = mem[g];
  end
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int NBYTES = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              busy,
  input logic              commit,
  input logic [NBYTES-1:0] buf_valid,
  input logic              page_err
);
  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);

  p_busy_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || buf_valid == $past(buf_valid)));

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> buf_valid == '0);

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  p_strobe_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(buf_valid) && !$fell(busy)) |-> $past(!ce_n && !we_n && oe_n, 2));
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.NBYTES(1 << OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .busy(busy), .commit(commit), .buf_valid(buf_valid), .page_err(page_err)
);

// File: tb/pgwr_ctrl_tb.sv
module pgwr_ctrl_tb;
  localparam int LW = 60, PC = 40, PN = 25, ML = 3;

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic busy, commit, page_err;
  logic [8:0] commit_page;
  logic [2047:0] buf_data;
  logic [255:0]  buf_valid;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pgwr_ctrl #(.LOAD_WIN(LW), .PROG_CYC(PC), .PON_CYC(PN), .MIN_LOW(ML)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .busy(busy), .commit(commit),
    .commit_page(commit_page), .buf_data(buf_data), .buf_valid(buf_valid),
    .page_err(page_err));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] byt(input int o);
    return buf_data[o*8 +: 8];
  endfunction

  task automatic load(input logic [8:0] pg, input logic [7:0] off, input logic [7:0] d,
                      input int nlow, input logic oe = 1'b1);
    @(negedge clk);
    addr = {pg, off}; din = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
    repeat (nlow) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b1;
  endtask

  task automatic finish_page(input logic [8:0] pg);
    int n = 0;
    int guard = 0;
    while (!commit && guard < LW + 40) begin @(negedge clk); guard++; end
    check("R6 commit seen", commit, 1'b1);
    check("R6 commit_page", commit_page, pg);
    while (busy) begin n++; @(negedge clk); end
    check("R6 busy length", n, PC);
    check("R10 valid cleared at busy fall", buf_valid == '0, 1'b1);
  endtask

  task automatic t_reset;
    check("R6 reset busy", busy, 1'b0);
    check("R6 reset commit", commit, 1'b0);
    check("R10 reset valid", buf_valid == '0, 1'b1);
    check("R5 reset err", page_err, 1'b0);
  endtask

  task automatic t_pon;
    load(9'h010, 8'd1, 8'hA5, ML);
    check("R8 load blocked during power-on delay", buf_valid == '0, 1'b1);
    repeat (PN + 5) @(negedge clk);
    load(9'h010, 8'd1, 8'hA5, ML);
    check("R8 load accepted after delay", buf_valid[1], 1'b1);
    finish_page(9'h010);
  endtask

  task automatic t_qualify;
    load(9'h020, 8'd4, 8'h11, ML, 1'b0);
    check("R1 oe low inhibits", buf_valid == '0, 1'b1);
    @(negedge clk); addr = {9'h020, 8'd4}; we_n = 1'b0;
    repeat (ML + 2) @(negedge clk); we_n = 1'b1; @(negedge clk);
    check("R1 we alone inhibits", buf_valid == '0, 1'b1);
    load(9'h020, 8'd4, 8'h11, ML);
    check("R1 valid load buffered", buf_valid[4], 1'b1);
    check("R1 valid load data", byt(4), 8'h11);
    finish_page(9'h020);
  endtask

  task automatic t_latch;
    @(negedge clk); addr = {9'h030, 8'd7}; din = 8'h01; ce_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = {9'h030, 8'd8}; we_n = 1'b0;
    @(negedge clk); addr = {9'h030, 8'd9};
    repeat (ML) @(negedge clk);
    we_n = 1'b1; din = 8'h5C;
    @(negedge clk); din = 8'hEE;
    repeat (2) @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    check("R2 address at later fall", buf_valid[8], 1'b1);
    check("R2 no load at earlier address", buf_valid[7] | buf_valid[9], 1'b0);
    check("R2 data at first rise", byt(8), 8'h5C);
    finish_page(9'h030);
  endtask

  task automatic t_glitch;
    load(9'h040, 8'd2, 8'h22, ML - 1);
    check("R3 short pulse rejected", buf_valid == '0, 1'b1);
    load(9'h040, 8'd2, 8'h22, ML);
    check("R3 minimum width accepted", buf_valid[2], 1'b1);
    finish_page(9'h040);
  endtask

  task automatic t_window;
    load(9'h050, 8'd0, 8'hA0, ML);
    repeat (LW - 12) @(negedge clk);
    check("R4 no start inside window (1)", busy, 1'b0);
    load(9'h050, 8'd1, 8'hA1, ML);
    repeat (LW - 12) @(negedge clk);
    check("R4 no start inside window (2)", busy, 1'b0);
    load(9'h050, 8'd5, 8'h11, ML);
    load(9'h050, 8'd5, 8'h22, ML);
    check("R9 latest data kept", byt(5), 8'h22);
    check("R9 single valid bit", $countones(buf_valid), 3);
    load(9'h051, 8'd6, 8'h66, ML);
    check("R5 foreign page sets error", page_err, 1'b1);
    check("R5 foreign page dropped", buf_valid[6], 1'b0);
    repeat (LW - 12) @(negedge clk);
    check("R4 window retriggered by last load", busy, 1'b0);
    check("R4 earlier bytes kept", {buf_valid[1], buf_valid[0]}, 2'b11);
    finish_page(9'h050);
    check("R5 error stays set", page_err, 1'b1);
  endtask

  task automatic t_busy_release;
    load(9'h060, 8'd3, 8'h33, ML);
    while (!commit) @(negedge clk);
    check("R6 commit page", commit_page, 9'h060);
    @(negedge clk);
    check("R6 commit one cycle", commit, 1'b0);
    load(9'h070, 8'd9, 8'h99, ML);
    check("R7 strobe during busy ignored", buf_valid[9], 1'b0);
    check("R7 buffer intact during busy", buf_valid[3], 1'b1);
    while (busy) @(negedge clk);
    check("R10 valid cleared on completion", buf_valid == '0, 1'b1);
    repeat (LW + 10) @(negedge clk);
    check("R7 no program from ignored strobe", busy, 1'b0);
    load(9'h070, 8'd9, 8'h99, ML);
    check("R10 new page accepted after release", buf_valid[9], 1'b1);
    finish_page(9'h070);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R4 R6): run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; pwr_good = 1'b1;
    t_pon();
    t_qualify();
    t_latch();
    t_glitch();
    t_window();
    t_busy_release();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule